// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block gathers the pending flags of a large set of pins into one interrupt line for the host. Pins are bundled in fours. Each bundle sets one bit of a registered summary vector. Software reads the summary as two 32-bit words. The low word carries summary bits 31:0. The high word carries bits 45:32 in its bits 13:0, and its remaining bits read as zero. The host line rises when the summary goes from empty to non-empty. Software re-arms the line by writing an end-of-interrupt bit into a master control register.

The master register also holds a blanking enable and a 12-bit blanking length. While the enable is set, a software write to any pin's debounce setting opens a global blanking window that lasts for the programmed number of slow-clock ticks. During the window the summary is held empty, so no new status or host interrupt can arise. The per-pin interrupt-enable bits, as presented for read-back, show zero for the same period. Detection of events at each pin is done elsewhere, and this block only sees the resulting pending flags.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: Summary bit n is the OR of the pending flags of pins 4n to 4n+3, with zero standing for the missing pins of a partial bundle. It appears on `stat_lo` (bits 31:0 of the summary) one clock after the flags are sampled.
- R2: `stat_hi` bits 13:0 carry summary bits 45:32, with the same one-clock latency. `stat_hi` bits 31:14 are always zero.
- R3: `host_irq` goes high on the clock after the one at which the summary changes from all-zero to non-zero, unless an end-of-interrupt write is sampled on that same clock.
- R4: A master write with bit 13 set is an end-of-interrupt. On the next clock `host_irq` is low and `mst_rd` bit 13 reads 1. One clock later `mst_rd` bit 13 reads 0 again, unless another end-of-interrupt was written.
- R5: On the clock after the end-of-interrupt bit reads 1, `host_irq` rises again if the summary is non-zero at that point. Otherwise it stays low.
- R6: In the master register, bits 11:0 hold the blanking length and bit 12 holds the blanking enable. Both are written by every master write, and both read back on `mst_rd` from the next clock. All other read bits are zero apart from bit 13.
- R7: With the enable set and a non-zero length L, a pulse on `dbnc_wr` starts a window. The window lasts until L `slow_tick` pulses have been counted. From the clock after the write until it ends, `int_en_rd` reads all zero, and the summary captured at each clock while the window is open is zero.
- R8: A `dbnc_wr` pulse has no effect while the enable is clear or the length is zero. After such a pulse `int_en_rd` keeps following `pin_int_en`, and the summary keeps following the pending flags.
- R9: A `dbnc_wr` pulse during an open window reloads the window to the full length L.
- R10: After a synchronous reset, the summary, `host_irq`, the master register and the blanking window are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period, used to count down the window |
| pin_pend | input | 184 | Pending flag of each pin from the per-pin detectors |
| pin_int_en | input | 184 | Raw interrupt-enable bit of each pin |
| dbnc_wr | input | 1 | Pulse when software writes any pin's debounce setting |
| mst_wr | input | 1 | Write strobe for the master register |
| mst_wdata | input | 32 | Master register write data |
| mst_rd | output | 32 | Master register read-back |
| stat_lo | output | 32 | Summary bits 31:0 |
| stat_hi | output | 32 | Summary bits 45:32 in bits 13:0 |
| int_en_rd | output | 184 | Interrupt-enable bits as read back, zero during a window |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The status words follow the pending flags one clock later. `host_irq` answers a new pending flag two clocks later: one clock for the summary register and one for the interrupt register. After an end-of-interrupt write it drops one clock later, and it can come back one clock after that. `int_en_rd` turns zero from the clock after the debounce write, because it is taken directly from the window counter. A behavioural model in the bench advances on each rising edge from the same inputs, and every output is compared with the model in the middle of each cycle, so each of these latencies is checked in the cycle it falls due. Directed sequences then check the reload and the ignored-write cases explicitly, a few clocks after the stimulus.

// File: rtl/gia_pkg.sv
// Package: shared constants of the grouped interrupt aggregator.
// Holds the master register field positions and the width of the blanking length.
package gia_pkg;
    localparam int REG_W   = 32;  // software register width
    localparam int LEN_W   = 12;  // blanking length field width
    localparam int LEN_LSB = 0;   // length field lowest bit
    localparam int EN_BIT  = 12;  // blanking enable bit
    localparam int EOI_BIT = 13;  // end-of-interrupt bit
endpackage

// File: rtl/gia_master_reg.sv
// Module: master control register.
// Holds the blanking length and enable, and produces the self-clearing
// end-of-interrupt flag. Assumes a write strobe of a single cycle per access.
module gia_master_reg
    import gia_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [LEN_W-1:0] len_o,
    output logic             en_o,
    output logic             eoi_o,
    output logic             eoi_wr_o,
    output logic [REG_W-1:0] rd_o
);
    logic [LEN_W-1:0] len_q;
    logic             en_q;
    logic             eoi_q;

    assign eoi_wr_o = wr && wdata[EOI_BIT];

    // Capture configuration fields and pulse the EOI flag for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            en_q  <= 1'b0;
            eoi_q <= 1'b0;
        end else begin
            eoi_q <= eoi_wr_o;
            if (wr) begin
                len_q <= wdata[LEN_LSB +: LEN_W];
                en_q  <= wdata[EN_BIT];
            end
        end
    end

    // Assemble the read-back word from the stored fields
    always_comb begin
        rd_o                    = '0;
        rd_o[LEN_LSB +: LEN_W]  = len_q;
        rd_o[EN_BIT]            = en_q;
        rd_o[EOI_BIT]           = eoi_q;
    end

    assign len_o = len_q;
    assign en_o  = en_q;
    assign eoi_o = eoi_q;

    AST_EOI_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_q && !eoi_wr_o) |=> !eoi_q); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(len_q) && $stable(en_q))); // R6
endmodule

// File: rtl/gia_blank_timer.sv
// Module: global blanking window counter.
// Loads the programmed length on a debounce write when blanking is enabled,
// and counts down once per slow tick. Assumes slow_tick is a one-cycle pulse.
module gia_blank_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbnc_wr,
    input  logic             slow_tick,
    input  logic             en,
    input  logic [LEN_W-1:0] len,
    output logic             blank_o
);
    logic [LEN_W-1:0] cnt_q;
    logic             arm;

    assign arm = dbnc_wr && en && (len != '0);

    // Reload on an armed write, otherwise count down on each slow tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= len;
        end else if (slow_tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blank_o = (cnt_q != '0);

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (cnt_q == $past(len))); // R9
    AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !arm) |=> (cnt_q == '0)); // R8
    AST_TICK_ONLY_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !slow_tick && !arm) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/gia_group_summary.sv
// Module: bundle-wise OR of pending flags into a registered summary.
// Pins beyond NUM_PINS in the last bundle count as not pending.
// While blank is high the captured summary is forced to zero.
module gia_group_summary #(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4,
    parameter int NUM_GRP      = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic                blank,
    output logic [NUM_GRP-1:0]  sum_o
);
    localparam int PAD_W = NUM_GRP * PINS_PER_GRP;

    logic [PAD_W-1:0]   pend_pad;
    logic [NUM_GRP-1:0] grp_or;
    logic [NUM_GRP-1:0] sum_q;

    // Zero-extend the flags to a whole number of bundles
    always_comb begin
        pend_pad                 = '0;
        pend_pad[NUM_PINS-1:0]   = pin_pend;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bundle
        assign grp_or[g] = |pend_pad[g*PINS_PER_GRP +: PINS_PER_GRP];
    end

    // Capture the bundle ORs, gated by the blanking window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= blank ? '0 : grp_or;
        end
    end

    assign sum_o = sum_q;

    AST_BLANK_SILENCES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (sum_q == '0)); // R7
    AST_EMPTY_INPUT_EMPTY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pend == '0) |=> (sum_q == '0)); // R1
endmodule

// File: rtl/gia_irq_gen.sv
// Module: host interrupt line with end-of-interrupt re-arm.
// Sets on a rise of the summary OR. Clears on an EOI write. One cycle after
// the EOI it sets again if anything is still pending.
module gia_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi_wr,
    input  logic eoi_q,
    output logic irq_o
);
    logic any_prev_q;
    logic irq_q;
    logic rise;

    assign rise = any_pend && !any_prev_q;

    // Remember the previous summary OR for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) any_prev_q <= 1'b0;
        else        any_prev_q <= any_pend;
    end

    // Interrupt state: EOI clears first, then rise or re-arm sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (eoi_wr) begin
            irq_q <= 1'b0;
        end else if (rise || (eoi_q && any_pend)) begin
            irq_q <= 1'b1;
        end
    end

    assign irq_o = irq_q;

    AST_EOI_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !irq_q); // R4
    AST_RISE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(any_pend) && !eoi_wr) |=> irq_q); // R3
    AST_REARM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_q && any_pend && !eoi_wr) |=> irq_q); // R5
endmodule

// File: rtl/gpio_irq_aggregator.sv
// Module: top of the grouped interrupt status aggregator.
// Joins the summary, blanking timer, master register and interrupt line,
// and splits the summary into two status words.
// Assumes NUM_GRP is above REG_W and at most twice REG_W.
module gpio_irq_aggregator
    import gia_pkg::*;
#(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_tick,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic [NUM_PINS-1:0] pin_int_en,
    input  logic                dbnc_wr,
    input  logic                mst_wr,
    input  logic [REG_W-1:0]    mst_wdata,
    output logic [REG_W-1:0]    mst_rd,
    output logic [REG_W-1:0]    stat_lo,
    output logic [REG_W-1:0]    stat_hi,
    output logic [NUM_PINS-1:0] int_en_rd,
    output logic                host_irq
);
    localparam int NUM_GRP = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP;
    localparam int SPLIT_W = 2 * REG_W;

    logic [LEN_W-1:0]   cfg_len;
    logic               cfg_en;
    logic               eoi_q;
    logic               eoi_wr;
    logic               blank;
    logic [NUM_GRP-1:0] sum;
    logic [SPLIT_W-1:0] sum_pad;

    gia_master_reg u_mst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (mst_wr),
        .wdata    (mst_wdata),
        .len_o    (cfg_len),
        .en_o     (cfg_en),
        .eoi_o    (eoi_q),
        .eoi_wr_o (eoi_wr),
        .rd_o     (mst_rd)
    );

    gia_blank_timer #(.LEN_W(LEN_W)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbnc_wr   (dbnc_wr),
        .slow_tick (slow_tick),
        .en        (cfg_en),
        .len       (cfg_len),
        .blank_o   (blank)
    );

    gia_group_summary #(
        .NUM_PINS     (NUM_PINS),
        .PINS_PER_GRP (PINS_PER_GRP),
        .NUM_GRP      (NUM_GRP)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_pend (pin_pend),
        .blank    (blank),
        .sum_o    (sum)
    );

    gia_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (|sum),
        .eoi_wr   (eoi_wr),
        .eoi_q    (eoi_q),
        .irq_o    (host_irq)
    );

    // Spread the summary over the low and high status words
    always_comb begin
        sum_pad                = '0;
        sum_pad[NUM_GRP-1:0]   = sum;
    end

    assign stat_lo   = sum_pad[REG_W-1:0];
    assign stat_hi   = sum_pad[SPLIT_W-1:REG_W];
    assign int_en_rd = blank ? '0 : pin_int_en;

    AST_WINDOW_HIDES_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && dbnc_wr && cfg_len != '0) |=> (int_en_rd == '0)); // R7
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_irq)) |-> ((stat_lo != '0) || (stat_hi != '0) || $past(stat_lo != '0 || stat_hi != '0))); // R3
endmodule

// File: tb/gpio_irq_aggregator_bench.sv
module gpio_irq_aggregator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 184;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_tick = 1'b0;
    logic [NP-1:0] pin_pend = '0;
    logic [NP-1:0] pin_int_en = '0;
    logic          dbnc_wr = 1'b0;
    logic          mst_wr = 1'b0;
    logic [31:0]   mst_wdata = '0;
    logic [31:0]   mst_rd, stat_lo, stat_hi;
    logic [NP-1:0] int_en_rd;
    logic          host_irq;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state
    logic [63:0] m_sum = '0;
    logic        m_prev = 0, m_irq = 0, m_eoi = 0, m_en = 0;
    int          m_len = 0, m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_aggregator u_gpio_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pin_pend(pin_pend),
        .pin_int_en(pin_int_en), .dbnc_wr(dbnc_wr), .mst_wr(mst_wr),
        .mst_wdata(mst_wdata), .mst_rd(mst_rd), .stat_lo(stat_lo),
        .stat_hi(stat_hi), .int_en_rd(int_en_rd), .host_irq(host_irq)
    );

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model advances on each rising edge
    always @(posedge clk) begin
        logic [63:0] nsum;
        logic        any, nirq, eoi_w;
        int          ncnt;
        if (!rst_n) begin
            m_sum = '0; m_prev = 0; m_irq = 0; m_eoi = 0; m_en = 0; m_len = 0; m_cnt = 0;
        end else begin
            nsum = '0;
            if (m_cnt == 0)
                for (int p = 0; p < NP; p++) if (pin_pend[p]) nsum[p/4] = 1'b1;
            any   = (m_sum != 0);
            eoi_w = mst_wr && mst_wdata[13];
            nirq  = m_irq;
            if (eoi_w) nirq = 0;
            else if ((any && !m_prev) || (m_eoi && any)) nirq = 1;
            ncnt = m_cnt;
            if (dbnc_wr && m_en && m_len != 0) ncnt = m_len;
            else if (slow_tick && m_cnt > 0) ncnt = m_cnt - 1;
            m_prev = any; m_irq = nirq; m_eoi = eoi_w; m_cnt = ncnt; m_sum = nsum;
            if (mst_wr) begin m_len = int'(mst_wdata[11:0]); m_en = mst_wdata[12]; end
        end
    end

    // Mid-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] erd;
        if (rst_n && !done) begin
            erd = 32'(m_len); erd[12] = m_en;
            check("R1 stat_lo", {160'b0, stat_lo}, {160'b0, m_sum[31:0]});
            check("R2 stat_hi", {160'b0, stat_hi}, {178'b0, m_sum[45:32]});
            check("R3 R5 host_irq", {191'b0, host_irq}, {191'b0, m_irq});
            check("R4 eoi_readback", {191'b0, mst_rd[13]}, {191'b0, m_eoi});
            check("R6 mst_rd", {160'b0, mst_rd & 32'hFFFF_DFFF}, {160'b0, erd});
            check("R7 int_en_rd", {8'b0, int_en_rd}, (m_cnt != 0) ? 192'b0 : {8'b0, pin_int_en});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_err++;
            $display("FAIL R10 watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic mwrite(input logic [31:0] d);
        mst_wr = 1; mst_wdata = d; cyc(); mst_wr = 0; mst_wdata = '0;
    endtask

    task automatic rand_pend(input bit sparse);
        for (int w = 0; w < 6; w++) begin
            logic [31:0] r;
            r = $urandom();
            if (sparse) r = r & $urandom() & $urandom() & $urandom();
            for (int b = 0; b < 32; b++) if (w*32 + b < NP) pin_pend[w*32 + b] = r[b];
        end
    endtask

    initial begin
        cyc(3);
        // R10: reset state seen on outputs while reset is still asserted
        check("R10 stat_lo", {160'b0, stat_lo}, 192'b0);
        check("R10 irq", {191'b0, host_irq}, 192'b0);
        check("R10 mst_rd", {160'b0, mst_rd}, 192'b0);
        rst_n = 1; pin_int_en = '1; cyc(2);

        // R1/R2 single pins and bundle edges
        pin_pend[0] = 1; cyc(); check("R1 pin0", {160'b0, stat_lo}, 192'h1);
        pin_pend = '0; pin_pend[7] = 1; cyc(); check("R1 pin7", {160'b0, stat_lo}, 192'h2);
        pin_pend = '0; pin_pend[130] = 1; cyc(); check("R2 pin130", {160'b0, stat_hi}, 192'h1);
        pin_pend = '0; pin_pend[183] = 1; cyc(); check("R2 pin183", {160'b0, stat_hi}, 192'h2000);
        pin_pend = '0; cyc(3);

        // R3 rise, R4 EOI drop, R5 re-arm while pending
        pin_pend[20] = 1; cyc(2); check("R3 irq_after_rise", {191'b0, host_irq}, 192'h1);
        mwrite(32'h2000); check("R4 irq_drop", {191'b0, host_irq}, 192'h0);
        check("R4 eoi_set", {191'b0, mst_rd[13]}, 192'h1);
        cyc(); check("R5 rearm", {191'b0, host_irq}, 192'h1);
        check("R4 eoi_clear", {191'b0, mst_rd[13]}, 192'h0);
        pin_pend = '0; cyc(2); mwrite(32'h2000); cyc(2);
        check("R5 no_rearm", {191'b0, host_irq}, 192'h0);

        // R7 window with length 5, tick every cycle
        mwrite(32'h1005); check("R6 cfg", {160'b0, mst_rd}, 192'h1005);
        slow_tick = 1; pin_pend[50] = 1; cyc(2);
        dbnc_wr = 1; cyc(); dbnc_wr = 0;
        check("R7 en_hidden", {8'b0, int_en_rd}, 192'b0);
        cyc(); check("R7 sum_blanked", {160'b0, stat_lo}, 192'b0);
        cyc(6); check("R7 en_back", {8'b0, int_en_rd}, {8'b0, pin_int_en});

        // R9 reload during the window, length 4
        mwrite(32'h1004);
        dbnc_wr = 1; cyc(); dbnc_wr = 0; cyc(2);
        dbnc_wr = 1; cyc(); dbnc_wr = 0; cyc(3);
        check("R9 still_blank", {8'b0, int_en_rd}, 192'b0);
        cyc(3);

        // R8 ignored writes: enable clear, then length zero
        mwrite(32'h0007); dbnc_wr = 1; cyc(); dbnc_wr = 0;
        check("R8 en_clear", {8'b0, int_en_rd}, {8'b0, pin_int_en});
        mwrite(32'h1000); dbnc_wr = 1; cyc(); dbnc_wr = 0;
        check("R8 len_zero", {8'b0, int_en_rd}, {8'b0, pin_int_en});
        cyc(); check("R8 sum_live", {160'b0, stat_lo}, {160'b0, 32'h1000});

        // Random mix, configuration kept small
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) rand_pend($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 5) == 0) pin_pend = '0;
            slow_tick = ($urandom_range(0, 1) == 1);
            dbnc_wr   = ($urandom_range(0, 40) == 0);
            pin_int_en[$urandom_range(0, NP-1)] ^= 1'b1;
            if ($urandom_range(0, 15) == 0) begin
                mst_wr = 1;
                mst_wdata = {18'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 12'($urandom_range(0, 9))};
            end else begin
                mst_wr = 0; mst_wdata = '0;
            end
            cyc();
        end
        mst_wr = 0; dbnc_wr = 0; cyc(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule